// File: doc/BRIEF.md
# Data EEPROM Controller with Self-Timed Writes

This block places a 2048-byte data EEPROM in the byte-wide external data space that a small processor reaches with its move-external instructions. Each request carries an 11-bit address, a write flag and a data byte. A control register on the special-function bus decides where the request goes. With the enable bit set, the request goes to an internal byte array. With the enable bit clear, the request is passed one cycle later to an external data bus port, and any read data comes back from that port.

Writes to the array also need a separate write-enable bit. Each accepted write starts a self-timed cycle whose length in clock cycles is a parameter. While that cycle runs, a read-only ready bit in the control register reads 0 and further writes are dropped. A read made during the cycle does not return the array contents. It returns the byte being written with its top bit inverted, so software can poll for completion through the data itself.

The requester waits for `mx_rvalid` after a read before it issues the next request.

Top module: `nvdata_ctrl`

## Requirements
- R1: After synchronous reset the enable and write-enable bits are 0, no write cycle is running, and the control register reads 8'h02.
- R2: The control register sits at SFR address 8'h96. Enable is bit 3, write-enable is bit 4, the read-only ready bit is bit 1, and every other bit reads 0. `sfr_rdata` shows the register one cycle after the address is presented. Any other address reads 8'h00, and a write to any other address changes nothing.
- R3: With enable at 0, a request appears on the external port one cycle later with the same address, data and write flag. External read data is returned on `mx_rdata` with `mx_rvalid` two cycles after the request.
- R4: With enable at 1, the external port stays idle. A read returns the array byte with `mx_rvalid` in the cycle after the request.
- R5: A write is stored when enable and write-enable are 1 and no write cycle is running.
- R6: A write made while write-enable is 0 leaves the array unchanged and starts no write cycle.
- R7: An accepted write makes the ready bit read 0 for exactly WR_CYCLES consecutive cycles.
- R8: A write made during a write cycle, including its final cycle, is ignored. A write in the first cycle after the cycle ends is accepted.
- R9: A read made during a write cycle returns the byte being written with bit 7 inverted, whatever the read address.
- R10: Once the write cycle ends, reads return the true stored byte.
- R11: All addresses from 11'h000 to 11'h7FF reach distinct array bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wr | input | 1 | Special-function register write strobe |
| sfr_wdata | input | 8 | Special-function register write data |
| sfr_rdata | output | 8 | Registered control register readback |
| mx_req | input | 1 | External-data-space request |
| mx_we | input | 1 | 1 = write, 0 = read |
| mx_addr | input | 11 | Request byte address |
| mx_wdata | input | 8 | Request write data |
| mx_rdata | output | 8 | Read data |
| mx_rvalid | output | 1 | Read data valid |
| ext_req | output | 1 | Forwarded request to the external port |
| ext_we | output | 1 | Forwarded write flag |
| ext_addr | output | 11 | Forwarded address |
| ext_wdata | output | 8 | Forwarded write data |
| ext_rdata | input | 8 | External read data, valid while ext_req is high |

## Verification
Two events can fall in the same clock cycle: the write cycle ends, and a new write request arrives. The bench uses a cycle counter to place one write at the final busy edge and the next write one edge later. It expects the first write to be dropped and the second to start a fresh busy window of WR_CYCLES cycles. It also reads during the window, in the cycle right after a write is accepted, and expects the inverted-MSB byte in the same cycle in which the timer has just started.

// File: rtl/nvdata_pkg.sv
package nvdata_pkg;
  localparam int CTRL_EN_BIT  = 3;
  localparam int CTRL_WEN_BIT = 4;
  localparam int CTRL_RDY_BIT = 1;
  localparam logic [7:0] CTRL_SFR_ADDR = 8'h96;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_ARRAY,
    SRC_SHADOW,
    SRC_EXT
  } rd_src_e;

  function automatic logic [7:0] flip_msb(input logic [7:0] b);
    return {~b[7], b[6:0]};
  endfunction
endpackage

// File: rtl/nvdata_csr.sv
module nvdata_csr
  import nvdata_pkg::*;
#(
  parameter int SFR_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_wdata,
  input  logic              busy,
  output logic              en,
  output logic              wen,
  output logic [7:0]        sfr_rdata
);
  logic       hit;
  logic [7:0] image;

  assign hit = (sfr_addr == SFR_AW'(CTRL_SFR_ADDR));

  always_comb begin
    image               = '0;
    image[CTRL_EN_BIT]  = en;
    image[CTRL_WEN_BIT] = wen;
    image[CTRL_RDY_BIT] = ~busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      wen       <= 1'b0;
      sfr_rdata <= '0;
    end else begin
      if (sfr_wr && hit) begin
        en  <= sfr_wdata[CTRL_EN_BIT];
        wen <= sfr_wdata[CTRL_WEN_BIT];
      end
      sfr_rdata <= hit ? image : 8'h00;
    end
  end
endmodule

// File: rtl/nvdata_timer.sv
module nvdata_timer #(
  parameter int WR_CYCLES = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= CW'(WR_CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/nvdata_array.sv
module nvdata_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nvdata_ctrl.sv
module nvdata_ctrl
  import nvdata_pkg::*;
#(
  parameter int AW        = 11,
  parameter int SFR_AW    = 8,
  parameter int WR_CYCLES = 30000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic              mx_req,
  input  logic              mx_we,
  input  logic [AW-1:0]     mx_addr,
  input  logic [7:0]        mx_wdata,
  output logic [7:0]        mx_rdata,
  output logic              mx_rvalid,
  output logic              ext_req,
  output logic              ext_we,
  output logic [AW-1:0]     ext_addr,
  output logic [7:0]        ext_wdata,
  input  logic [7:0]        ext_rdata
);
  logic       ctl_en, ctl_wen, wr_busy;
  logic       wr_go, int_rd, ext_go;
  logic [7:0] arr_q, wbyte_q, ext_q;
  rd_src_e    src_q;

  assign wr_go  = mx_req && mx_we && ctl_en && ctl_wen && !wr_busy;
  assign int_rd = mx_req && !mx_we && ctl_en;
  assign ext_go = mx_req && !ctl_en;

  nvdata_csr #(.SFR_AW(SFR_AW)) i_csr (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .busy(wr_busy), .en(ctl_en), .wen(ctl_wen),
    .sfr_rdata(sfr_rdata)
  );

  nvdata_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
    .clk(clk), .rst(rst), .start(wr_go), .busy(wr_busy)
  );

  nvdata_array #(.AW(AW), .DW(8)) i_array (
    .clk(clk), .we(wr_go), .addr(mx_addr), .wdata(mx_wdata), .rdata(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wbyte_q   <= '0;
      ext_req   <= 1'b0;
      ext_we    <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
      ext_q     <= '0;
      src_q     <= SRC_NONE;
    end else begin
      if (wr_go) wbyte_q <= mx_wdata;
      ext_req <= ext_go;
      ext_we  <= ext_go && mx_we;
      if (ext_go) begin
        ext_addr  <= mx_addr;
        ext_wdata <= mx_wdata;
      end
      ext_q <= ext_rdata;
      if (ext_req && !ext_we) src_q <= SRC_EXT;
      else if (int_rd)        src_q <= wr_busy ? SRC_SHADOW : SRC_ARRAY;
      else                    src_q <= SRC_NONE;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_ARRAY:  mx_rdata = arr_q;
      SRC_SHADOW: mx_rdata = flip_msb(wbyte_q);
      SRC_EXT:    mx_rdata = ext_q;
      default:    mx_rdata = 8'h00;
    endcase
  end

  assign mx_rvalid = (src_q != SRC_NONE);
endmodule

// File: rtl/nvdata_ctrl_chk.sv
module nvdata_ctrl_chk #(
  parameter int AW     = 11,
  parameter int SFR_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mx_req,
  input logic              mx_we,
  input logic [AW-1:0]     mx_addr,
  input logic              ctl_en,
  input logic              ctl_wen,
  input logic              wr_busy,
  input logic              ext_req,
  input logic [AW-1:0]     ext_addr,
  input logic [SFR_AW-1:0] sfr_addr,
  input logic [7:0]        sfr_rdata
);
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!wr_busy && !ctl_en && !ctl_wen));

  p_ready_mirror_r2: assert property (@(posedge clk) disable iff (rst)
    (sfr_addr == SFR_AW'(8'h96)) |=> (sfr_rdata[1] == !$past(wr_busy)));

  p_ext_forward_r3: assert property (@(posedge clk) disable iff (rst)
    (mx_req && !ctl_en) |=> (ext_req && ext_addr == $past(mx_addr)));

  p_ext_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (mx_req && ctl_en) |=> !ext_req);

  p_accept_starts_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (mx_req && mx_we && ctl_en && ctl_wen && !wr_busy) |=> wr_busy);

  p_no_start_without_wen_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_busy && !(mx_req && mx_we && ctl_en && ctl_wen)) |=> !wr_busy);
endmodule

bind nvdata_ctrl nvdata_ctrl_chk #(.AW(AW), .SFR_AW(SFR_AW)) i_chk (
  .clk(clk), .rst(rst), .mx_req(mx_req), .mx_we(mx_we), .mx_addr(mx_addr),
  .ctl_en(ctl_en), .ctl_wen(ctl_wen), .wr_busy(wr_busy), .ext_req(ext_req),
  .ext_addr(ext_addr), .sfr_addr(sfr_addr), .sfr_rdata(sfr_rdata)
);

// File: tb/test_nvdata_ctrl.sv
module test_nvdata_ctrl;
  localparam int CLK_P = 10;
  localparam int W     = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_wr;
  logic        mx_req, mx_we, mx_rvalid;
  logic [10:0] mx_addr;
  logic [7:0]  mx_wdata, mx_rdata;
  logic        ext_req, ext_we;
  logic [10:0] ext_addr;
  logic [7:0]  ext_wdata, ext_rdata;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  bit en_m = 0, wen_m = 0;
  logic [7:0] mem_m [2048];
  bit         vld_m [2048];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] ext_model(input logic [10:0] a);
    return a[7:0] ^ {5'b0, a[10:8]} ^ 8'hA5;
  endfunction
  function automatic logic [7:0] inv_top(input logic [7:0] b);
    return {~b[7], b[6:0]};
  endfunction

  assign ext_rdata = ext_model(ext_addr);

  nvdata_ctrl #(.WR_CYCLES(W)) i_nvdata_ctrl (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .mx_req(mx_req),
    .mx_we(mx_we), .mx_addr(mx_addr), .mx_wdata(mx_wdata),
    .mx_rdata(mx_rdata), .mx_rvalid(mx_rvalid), .ext_req(ext_req),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] v);
    sfr_addr = a; sfr_wdata = v; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_addr = 8'h96;
    if (a == 8'h96) begin en_m = v[3]; wen_m = v[4]; end
  endtask

  task automatic sfr_check(input string req, input logic [7:0] exp);
    sfr_addr = 8'h96;
    @(negedge clk);
    chk(req, sfr_rdata, exp);
  endtask

  task automatic mx_write(input logic [10:0] a, input logic [7:0] d);
    mx_req = 1'b1; mx_we = 1'b1; mx_addr = a; mx_wdata = d;
    @(negedge clk);
    mx_req = 1'b0; mx_we = 1'b0;
    if (!en_m) begin
      chk("R3 ext_req on write", ext_req, 1);
      chk("R3 ext_we", ext_we, 1);
      chk("R3 ext_addr", ext_addr, a);
      chk("R3 ext_wdata", ext_wdata, d);
    end else begin
      chk("R4 ext idle on write", ext_req, 0);
    end
  endtask

  task automatic mx_read(input string req, input logic [10:0] a, input logic [7:0] exp);
    mx_req = 1'b1; mx_we = 1'b0; mx_addr = a;
    @(negedge clk);
    mx_req = 1'b0;
    if (en_m) begin
      chk("R4 ext idle on read", ext_req, 0);
      chk({req, " rvalid"}, mx_rvalid, 1);
      chk(req, mx_rdata, exp);
    end else begin
      chk("R3 ext_req on read", ext_req, 1);
      chk("R3 ext_addr on read", ext_addr, a);
      @(negedge clk);
      chk({req, " rvalid"}, mx_rvalid, 1);
      chk(req, mx_rdata, exp);
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    for (int i = 0; i < 4 * W; i++) begin
      @(negedge clk);
      if (sfr_rdata[1] == 1'b0) n++;
      else if (n > 0) break;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, t_acc;
    logic [31:0] r;
    logic [10:0] a;
    void'($urandom(32'd1234));
    rst = 1'b1; sfr_addr = 8'h96; sfr_wdata = '0; sfr_wr = 1'b0;
    mx_req = 1'b0; mx_we = 1'b0; mx_addr = '0; mx_wdata = '0;
    for (int i = 0; i < 2048; i++) vld_m[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset control", sfr_rdata, 8'h02);
    chk("R1 ext idle", ext_req, 0);
    chk("R1 no rvalid", mx_rvalid, 0);

    // R2 decode and bit positions
    sfr_addr = 8'h55; @(negedge clk);
    chk("R2 other address", sfr_rdata, 8'h00);
    sfr_write(8'h96, 8'hFF);
    sfr_check("R2 all bits set", 8'h1A);
    sfr_write(8'h96, 8'h00);
    sfr_check("R2 cleared", 8'h02);
    sfr_write(8'h97, 8'hFF);
    sfr_check("R2 foreign write", 8'h02);

    // R3 external routing
    mx_write(11'h123, 8'h3C);
    mx_read("R3 ext read", 11'h456, ext_model(11'h456));

    // R5 R7 R11 array writes
    sfr_write(8'h96, 8'h18);
    mx_write(11'h000, 8'h11);
    count_busy(n);
    chk("R7 busy length", n, W);
    mx_read("R5 stored byte", 11'h000, 8'h11);
    mx_write(11'h7FF, 8'hEE);
    count_busy(n);
    mx_read("R11 top address", 11'h7FF, 8'hEE);
    mx_read("R11 bottom distinct", 11'h000, 8'h11);

    // R6 write without write-enable
    sfr_write(8'h96, 8'h08);
    mx_write(11'h000, 8'h99);
    count_busy(n);
    chk("R6 no busy", n, 0);
    mx_read("R6 array unchanged", 11'h000, 8'h11);

    // R9 R8 R10 during a write cycle
    sfr_write(8'h96, 8'h18);
    mx_write(11'h030, 8'h44);
    count_busy(n);
    mx_write(11'h010, 8'h5A);
    t_acc = cyc;
    mx_read("R9 shadow other address", 11'h7FF, 8'hDA);
    mx_write(11'h7FF, 8'h01);
    while (cyc < t_acc + W - 1) @(negedge clk);
    mx_write(11'h030, 8'h77);
    t_acc = cyc;
    mx_write(11'h031, 8'h66);
    count_busy(n);
    chk("R8 next-cycle write accepted", n, W);
    mx_read("R8 final-cycle write ignored", 11'h030, 8'h44);
    mx_read("R8 early write ignored", 11'h7FF, 8'hEE);
    mx_read("R10 true data", 11'h010, 8'h5A);
    mx_read("R8 accepted data", 11'h031, 8'h66);

    mem_m[11'h000] = 8'h11; vld_m[11'h000] = 1;
    mem_m[11'h7FF] = 8'hEE; vld_m[11'h7FF] = 1;
    mem_m[11'h030] = 8'h44; vld_m[11'h030] = 1;
    mem_m[11'h010] = 8'h5A; vld_m[11'h010] = 1;
    mem_m[11'h031] = 8'h66; vld_m[11'h031] = 1;

    // random mix
    for (int k = 0; k < 150; k++) begin
      r = $urandom;
      sfr_write(8'h96, {3'b0, r[1], r[0], 3'b0});
      a = {r[7:4], 4'b0, r[10:8]};
      if (r[2]) begin
        mx_write(a, r[31:24]);
        if (en_m && wen_m) begin
          mem_m[a] = r[31:24]; vld_m[a] = 1;
          mx_read("R9 random shadow", a ^ 11'h001, inv_top(r[31:24]));
          repeat (W + 1) @(negedge clk);
        end
      end else if (!en_m) begin
        mx_read("R3 random ext", a, ext_model(a));
      end else if (vld_m[a]) begin
        mx_read("R5 random array", a, mem_m[a]);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule